// File: doc/BRIEF.md
# White Level Tracker

This block holds the 8-bit code for an external DAC whose output sets the reference of a white-detect comparator. The raw comparator output arrives on `white_in` and the horizontal sync pulse on `hsync`. A line counts as white when the comparator output stays high for a minimum run of consecutive clock cycles somewhere in that line. The block adds up the white lines of each frame.

A frame does not come from a vertical sync input. The block closes a frame after a fixed number of horizontal sync edges. At that point it compares the white-line total with a two-sided band. A total above the band raises the code by a fixed step and pulses `dac_up`. A total below the band lowers the code by the same step and pulses `dac_down`. A total inside the band leaves the code alone. The threshold therefore follows the brightness of the scene. The analog DAC and the comparator are outside the block.

Top module: `white_level_tracker`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `dac_code` is 128 and both `dac_up` and `dac_down` are low. Reset also clears the line and white-line counters.
- R2: A frame ends on every 254th rising edge of `hsync` after reset. Each edge closes the current line. No strobe occurs during a frame before that frame's last edge.
- R3: A line is white only if `white_in` is high for at least 3 consecutive clock cycles before the edge that closes it. Shorter runs, and runs broken by single low cycles, do not make the line white.
- R4: A white line counts once in the frame total, however many qualifying runs it holds.
- R5: When the frame total is greater than 50, exactly one `dac_up` pulse follows the frame end. `dac_code` then rises by 7.
- R6: When the frame total is less than 20, exactly one `dac_down` pulse follows the frame end. `dac_code` then falls by 7.
- R7: When the frame total lies between 20 and 50 inclusive, neither strobe pulses and `dac_code` is unchanged.
- R8: `dac_code` saturates at 255 going up and at 0 going down, and never wraps. The strobe is still issued when the code is already at its limit.
- R9: Each strobe is high for exactly one cycle. The two strobes are never high together, and each evaluation gives at most one strobe. `dac_code` changes only in the cycle after a strobe.
- R10: The white-line total starts again from zero in each frame. Lines from earlier frames never add into a later decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync | input | 1 | Horizontal sync; each rising edge closes a line |
| white_in | input | 1 | Raw white comparator output |
| dac_code | output | 8 | Threshold code for the DAC |
| dac_up | output | 1 | One-cycle pulse when the threshold is raised |
| dac_down | output | 1 | One-cycle pulse when the threshold is lowered |

## Verification
The bench drives totals exactly at 50 and 20, and one step past each. A design with an off-by-one comparison would pulse on a band edge, or stay silent one line past it. Lines with two-cycle runs, with broken single-cycle pulses, and with two full runs each expose a run qualifier that triggers too early or counts a line twice. Back-to-back in-band frames expose a total that is not cleared at the frame boundary. A check just before the 254th edge catches a frame length that is off by one. Long runs of saturating frames, plus a reset in the middle of a frame, expose a code that wraps past 255 or 0, or a reset that leaves stale state behind.

// File: rtl/wlt_pkg.sv
package wlt_pkg;

    localparam int FRAME_CNT_W = 16;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EVAL,
        ST_RAISE,
        ST_LOWER
    } judge_state_t;

    typedef struct packed {
        logic                   valid;
        logic [FRAME_CNT_W-1:0] count;
    } frame_report_t;

    typedef struct packed {
        logic up;
        logic down;
    } strobe_t;

    function automatic int unsigned clamp_step(int unsigned cur, int unsigned step,
                                               logic raise, int unsigned top);
        if (raise) begin
            return (cur + step > top) ? top : cur + step;
        end
        return (cur < step) ? 0 : cur - step;
    endfunction

endpackage

// File: rtl/wlt_run_qualifier.sv
module wlt_run_qualifier #(
    parameter int MIN_RUN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic line_end,
    input  logic white_in,
    output logic line_white
);
    localparam int RUN_W = $clog2(MIN_RUN + 1);

    logic [RUN_W-1:0] run_q;
    logic [RUN_W-1:0] run_next;
    logic             hit;
    logic             flag_q;

    always_comb begin
        hit = white_in && (run_q >= RUN_W'(MIN_RUN - 1));
        if (!white_in) begin
            run_next = '0;
        end else if (run_q == RUN_W'(MIN_RUN)) begin
            run_next = run_q;
        end else begin
            run_next = run_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || line_end) begin
            run_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            run_q <= run_next;
            if (hit) begin
                flag_q <= 1'b1;
            end
        end
    end

    assign line_white = flag_q;

    // R3: the line flag only rises after the comparator was high
    a_r3_flag_needs_white: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(white_in));

    // R4: a set flag stays set until the line closes
    a_r4_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        ($past(flag_q) && !$past(line_end)) |-> flag_q);

endmodule

// File: rtl/wlt_frame_counter.sv
module wlt_frame_counter
    import wlt_pkg::*;
#(
    parameter int LINES = 254
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          line_end,
    input  logic          line_white,
    output frame_report_t report
);
    localparam int LINE_W = (LINES > 1) ? $clog2(LINES) : 1;

    logic [LINE_W-1:0]      line_q;
    logic [FRAME_CNT_W-1:0] white_q;
    frame_report_t          report_q;
    logic                   last_line;

    assign last_line = (line_q == LINE_W'(LINES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q   <= '0;
            white_q  <= '0;
            report_q <= '0;
        end else begin
            report_q.valid <= 1'b0;
            if (line_end) begin
                if (last_line) begin
                    line_q         <= '0;
                    white_q        <= '0;
                    report_q.valid <= 1'b1;
                    report_q.count <= white_q + FRAME_CNT_W'(line_white);
                end else begin
                    line_q  <= line_q + 1'b1;
                    white_q <= white_q + FRAME_CNT_W'(line_white);
                end
            end
        end
    end

    assign report = report_q;

    // R2: the line index never leaves the frame
    a_r2_line_in_frame: assert property (@(posedge clk) disable iff (rst)
        line_q <= LINE_W'(LINES - 1));

    // R10: the white total restarts at every frame boundary
    a_r10_total_cleared: assert property (@(posedge clk) disable iff (rst)
        (line_end && last_line) |=> (white_q == '0));

endmodule

// File: rtl/wlt_judge.sv
module wlt_judge
    import wlt_pkg::*;
#(
    parameter int DAC_W   = 8,
    parameter int STEP    = 7,
    parameter int HI_LIM  = 50,
    parameter int LO_LIM  = 20,
    parameter int RESET_CODE = 128
) (
    input  logic          clk,
    input  logic          rst,
    input  frame_report_t report,
    output logic [DAC_W-1:0] code,
    output strobe_t       strobe
);
    localparam int CODE_MAX = (1 << DAC_W) - 1;

    judge_state_t           state_q;
    logic [FRAME_CNT_W-1:0] total_q;
    logic [DAC_W-1:0]       code_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            total_q <= '0;
            code_q  <= DAC_W'(RESET_CODE);
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (report.valid) begin
                        total_q <= report.count;
                        state_q <= ST_EVAL;
                    end
                end
                ST_EVAL: begin
                    if (total_q > FRAME_CNT_W'(HI_LIM)) begin
                        state_q <= ST_RAISE;
                    end else if (total_q < FRAME_CNT_W'(LO_LIM)) begin
                        state_q <= ST_LOWER;
                    end else begin
                        state_q <= ST_IDLE;
                    end
                end
                ST_RAISE: begin
                    code_q  <= DAC_W'(clamp_step(32'(code_q), STEP, 1'b1, CODE_MAX));
                    state_q <= ST_IDLE;
                end
                ST_LOWER: begin
                    code_q  <= DAC_W'(clamp_step(32'(code_q), STEP, 1'b0, CODE_MAX));
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign strobe.up   = (state_q == ST_RAISE);
    assign strobe.down = (state_q == ST_LOWER);
    assign code        = code_q;

    // R9: strobes are exclusive and one cycle wide
    a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
        $countones({strobe.up, strobe.down}) <= 1);
    a_r9_up_single: assert property (@(posedge clk) disable iff (rst)
        strobe.up |=> !strobe.up);
    a_r9_down_single: assert property (@(posedge clk) disable iff (rst)
        strobe.down |=> !strobe.down);

    // R7 / R9: without a strobe the code holds
    a_r7_code_holds: assert property (@(posedge clk) disable iff (rst)
        (!strobe.up && !strobe.down) |=> $stable(code_q));

    // R8: no wrap in either direction
    a_r8_no_wrap_up: assert property (@(posedge clk) disable iff (rst)
        strobe.up |=> (code_q >= $past(code_q)));
    a_r8_no_wrap_down: assert property (@(posedge clk) disable iff (rst)
        strobe.down |=> (code_q <= $past(code_q)));

endmodule

// File: rtl/white_level_tracker.sv
module white_level_tracker
    import wlt_pkg::*;
#(
    parameter int DAC_W      = 8,
    parameter int STEP       = 7,
    parameter int HI_LIM     = 50,
    parameter int LO_LIM     = 20,
    parameter int LINES      = 254,
    parameter int MIN_RUN    = 3,
    parameter int RESET_CODE = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hsync,
    input  logic             white_in,
    output logic [DAC_W-1:0] dac_code,
    output logic             dac_up,
    output logic             dac_down
);
    logic          hsync_q;
    logic          line_end;
    logic          line_white;
    frame_report_t report;
    strobe_t       strobe;

    always_ff @(posedge clk) begin
        if (rst) begin
            hsync_q <= 1'b0;
        end else begin
            hsync_q <= hsync;
        end
    end

    assign line_end = hsync && !hsync_q;

    wlt_run_qualifier #(.MIN_RUN(MIN_RUN)) u_qual (
        .clk        (clk),
        .rst        (rst),
        .line_end   (line_end),
        .white_in   (white_in),
        .line_white (line_white)
    );

    wlt_frame_counter #(.LINES(LINES)) u_frame (
        .clk        (clk),
        .rst        (rst),
        .line_end   (line_end),
        .line_white (line_white),
        .report     (report)
    );

    wlt_judge #(
        .DAC_W      (DAC_W),
        .STEP       (STEP),
        .HI_LIM     (HI_LIM),
        .LO_LIM     (LO_LIM),
        .RESET_CODE (RESET_CODE)
    ) u_judge (
        .clk    (clk),
        .rst    (rst),
        .report (report),
        .code   (dac_code),
        .strobe (strobe)
    );

    assign dac_up   = strobe.up;
    assign dac_down = strobe.down;

    // R1: reset state visible right after release
    a_r1_reset_code: assert property (@(posedge clk)
        $past(rst) |-> (dac_code == DAC_W'(RESET_CODE) && !dac_up && !dac_down));

endmodule

// File: tb/test_white_level_tracker.sv
module test_white_level_tracker;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hsync = 1'b0;
    logic       white_in = 1'b0;
    logic [7:0] dac_code;
    logic       dac_up;
    logic       dac_down;

    int tests = 0;
    int fails = 0;
    int up_n = 0;
    int down_n = 0;
    int shape_err = 0;
    logic up_prev = 1'b0;
    logic down_prev = 1'b0;
    int exp_code = 128;

    always #5 clk = ~clk;

    white_level_tracker i_white_level_tracker (
        .clk      (clk),
        .rst      (rst),
        .hsync    (hsync),
        .white_in (white_in),
        .dac_code (dac_code),
        .dac_up   (dac_up),
        .dac_down (dac_down)
    );

    // strobe monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (dac_up) up_n++;
            if (dac_down) down_n++;
            if ((dac_up && up_prev) || (dac_down && down_prev) || (dac_up && dac_down))
                shape_err++;
        end
        up_prev   <= dac_up;
        down_prev <= dac_down;
    end

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input logic w);
        @(posedge clk);
        #1;
        white_in = w;
        hsync    = 1'b0;
    endtask

    // kind: 0 dark, 1 one run of 3, 2 run of 2, 3 two runs of 3, 4 broken pulses
    task automatic drive_line(input int kind);
        case (kind)
            1: begin tick(1); tick(1); tick(1); tick(0); end
            2: begin tick(1); tick(1); tick(0); tick(0); end
            3: begin tick(1); tick(1); tick(1); tick(0); tick(1); tick(1); tick(1); tick(0); end
            4: begin tick(1); tick(0); tick(1); tick(0); tick(1); tick(0); end
            default: begin tick(0); tick(0); tick(0); end
        endcase
        @(posedge clk);
        #1;
        hsync = 1'b1;
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) tick(0);
    endtask

    function automatic int model_step(input int cur, input int dir);
        if (dir > 0) return (cur + 7 > 255) ? 255 : cur + 7;
        if (dir < 0) return (cur < 7) ? 0 : cur - 7;
        return cur;
    endfunction

    // one full frame of 254 lines; dir: +1 up, -1 down, 0 none
    task automatic run_frame(input int n_white, input int kind, input int dir, input string req);
        int u0 = up_n;
        int d0 = down_n;
        for (int i = 0; i < 254; i++) begin
            if (i == 253) begin
                check({req, " R2 no strobe before frame end"}, up_n + down_n - u0 - d0, 0);
            end
            drive_line(i < n_white ? kind : 0);
        end
        wait_cycles(6);
        exp_code = model_step(exp_code, dir);
        check({req, " up pulses"}, up_n - u0, dir > 0 ? 1 : 0);
        check({req, " down pulses"}, down_n - d0, dir < 0 ? 1 : 0);
        check({req, " code"}, dac_code, exp_code);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        wait_cycles(3);
        @(negedge clk);
        check("R1 code during reset", dac_code, 128);
        check("R1 strobes during reset", dac_up | dac_down, 0);
        @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        check("R1 code after release", dac_code, 128);
        check("R1 strobes after release", dac_up | dac_down, 0);
        exp_code = 128;
    endtask

    task automatic t_band();
        run_frame(35, 1, 0, "R7 mid band");
        run_frame(60, 1, 1, "R5 above band");
        run_frame(5, 1, -1, "R6 below band");
    endtask

    task automatic t_edges();
        run_frame(50, 1, 0, "R7 at upper edge");
        run_frame(20, 1, 0, "R7 at lower edge");
        run_frame(51, 1, 1, "R5 one past upper");
        run_frame(19, 1, -1, "R6 one past lower");
    endtask

    task automatic t_qualifier();
        run_frame(60, 2, -1, "R3 two-cycle runs");
        run_frame(60, 4, -1, "R3 broken pulses");
    endtask

    task automatic t_once_per_line();
        run_frame(30, 3, 0, "R4 double runs 30 lines");
        run_frame(15, 3, -1, "R4 double runs 15 lines");
    endtask

    task automatic t_clear();
        run_frame(40, 1, 0, "R10 first frame");
        run_frame(40, 1, 0, "R10 second frame");
    endtask

    task automatic t_sat_up();
        do_reset();
        for (int f = 0; f < 20; f++) run_frame(100, 1, 1, "R8 climb");
        check("R8 top code", dac_code, 255);
    endtask

    task automatic t_sat_down();
        for (int i = 0; i < 120; i++) drive_line(1);
        do_reset();
        for (int f = 0; f < 20; f++) run_frame(0, 0, -1, "R8 descent");
        check("R8 bottom code", dac_code, 0);
    endtask

    initial begin
        #1500000;
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        do_reset();
        t_band();
        t_edges();
        t_qualifier();
        t_once_per_line();
        t_clear();
        t_sat_up();
        t_sat_down();
        check("R9 strobe shape", shape_err, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule